// File: doc/BRIEF.md
# Stream Buffer Row Arbiter

This block is the front end of a stream register file. A number of stream buffers share one wide, single-ported row memory. On the cluster side each buffer is a small FIFO that moves 32-bit words through a valid/ready port. Behind it, an arbiter grants the memory port to at most one buffer per cycle. The granted buffer then moves a whole row of 64 words in one cycle. For a load stream that transfer is a row read into the FIFO. For a store stream it is a row write out of the FIFO.

Each stream is set up by a one-cycle configure strobe. The strobe carries a starting row, a length in words and a direction. The stream's row pointer then advances by one row per transfer. A done flag reports when the configured length has been fully moved and the FIFO is empty. The default memory is 1024 rows of 2048 bits, which is 64K words. Each FIFO holds two rows, so one row can move across the memory port while the cluster works on the other.

Top module: `sbarb_srf_frontend`

## Requirements
- R1: At most one stream is granted the memory port in any cycle, and only a stream that is requesting it. A granted store writes its row and a granted load reads its row, so no two row accesses share a cycle.
- R2: A load stream requests when words remain to fetch, no row is in flight and its FIFO has at least 64 free entries. The row read at the grant edge enters the FIFO at the next edge. Its words then leave in order on the word port: out_valid is high while the FIFO is non-empty, and a word is consumed when out_valid and out_ready are both high.
- R3: Arbitration is round-robin, starting after the last granted stream. A stream that keeps requesting waits for at most N_STREAMS-1 grants to other streams.
- R4: A store stream requests when its FIFO holds at least 64 words, or when all its words have been accepted and the FIFO is not empty. In a final partial row, the word slots past the last stored word are written as zero.
- R5: Each transfer advances the stream's row pointer by one. The pointer wraps from the last row to row 0.
- R6: The final row of a load delivers only the remaining words of the configured length into the FIFO.
- R7: done is high when no words remain to move, no row is in flight and the FIFO is empty. Configuring a length of 0 gives done at the next cycle.
- R8: A configure strobe empties that stream's FIFO and cancels any row in flight. It then loads the row, length and direction (0 = load, 1 = store). After reset every stream is an idle load stream: done is 1, out_valid is 0 and in_ready is 0.
- R9: A store stream accepts words only while words of its length remain and its FIFO holds fewer than 128 words. in_ready shows that condition.
- R10: Word j of a row occupies row bits [32j+31:32j]. A row written by a store and read back by a load returns the words in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | N_STREAMS | Per-stream configure strobe |
| cfg_row | input | N_STREAMS x 10 | Starting row per stream |
| cfg_len | input | N_STREAMS x 17 | Length in words per stream |
| cfg_dir | input | N_STREAMS | Direction per stream, 0 load, 1 store |
| in_valid | input | N_STREAMS | Store word valid |
| in_data | input | N_STREAMS x 32 | Store word data |
| in_ready | output | N_STREAMS | Store word accepted when valid |
| out_valid | output | N_STREAMS | Load word available |
| out_data | output | N_STREAMS x 32 | Load word data |
| out_ready | input | N_STREAMS | Load word consumer ready |
| done | output | N_STREAMS | Stream complete |

## Verification
A corrupted FIFO pointer or count shows at the word ports within a cycle: out_valid or in_ready goes out of step with the model, or a wrong word appears at the head of the FIFO. A wrong row pointer or grant has a slower effect. Its data lands in the wrong row, and it shows only when a later load reads that row back, typically a few hundred cycles later. The comparison of the read-back words against the words that were stored is therefore the check that catches such faults. A broken arbiter shows either as words arriving out of the modelled order or as a stream that never reaches done.

// File: rtl/sbarb_pkg.sv
package sbarb_pkg;
    typedef enum logic {
        SB_LOAD  = 1'b0,
        SB_STORE = 1'b1
    } sb_dir_e;
endpackage

// File: rtl/sbarb_rr_arbiter.sv
module sbarb_rr_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [IW-1:0] last;
    } arb_t;

    arb_t arb_q, arb_d;
    logic found;

    // search starts one past the previous winner
    always_comb begin
        arb_d = arb_q;
        gnt   = '0;
        found = 1'b0;
        for (int off = 1; off <= N; off++) begin
            logic [IW-1:0] ix;
            ix = IW'((int'(arb_q.last) + off) % N);
            if (!found && req[ix]) begin
                gnt[ix]    = 1'b1;
                found      = 1'b1;
                arb_d.last = ix;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    // R1: one row access per cycle, only to a requester
    assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~req) == '0));

    // R3: bounded wait, counted per requester
    logic [N-1:0][IW:0] wait_q;
    for (genvar i = 0; i < N; i++) begin : g_fair
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          wait_q[i] <= '0;
            else if (!req[i] || gnt[i])          wait_q[i] <= '0;
            else if (|gnt)                       wait_q[i] <= wait_q[i] + (IW+1)'(1);
        end
        assert_bounded_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
            int'(wait_q[i]) < N);
    end
endmodule

// File: rtl/sbarb_row_sram.sv
module sbarb_row_sram #(
    parameter int ROWS     = 1024,
    parameter int ROW_BITS = 2048,
    parameter int ROW_AW   = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                en,
    input  logic                we,
    input  logic [ROW_AW-1:0]   addr,
    input  logic [ROW_BITS-1:0] wdata,
    output logic [ROW_BITS-1:0] rdata
);
    logic [ROW_BITS-1:0] mem [ROWS];
    logic [ROW_BITS-1:0] rdata_q;

    // single port: either a write or a read per enabled cycle
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata_q   <= mem[addr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/sbarb_stream_buf.sv
module sbarb_stream_buf
    import sbarb_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int ROW_WORDS = 64,
    parameter int ROW_AW    = 10,
    parameter int LEN_W     = 17
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_valid,
    input  logic [ROW_AW-1:0]           cfg_row,
    input  logic [LEN_W-1:0]            cfg_len,
    input  logic                        cfg_dir,
    input  logic                        in_valid,
    input  logic [WORD_W-1:0]           in_data,
    output logic                        in_ready,
    output logic                        out_valid,
    output logic [WORD_W-1:0]           out_data,
    input  logic                        out_ready,
    output logic                        done,
    output logic                        req,
    input  logic                        gnt,
    output logic [ROW_AW-1:0]           row_addr,
    output logic                        row_we,
    output logic [WORD_W*ROW_WORDS-1:0] row_wdata,
    input  logic [WORD_W*ROW_WORDS-1:0] row_rdata
);
    localparam int CAP   = 2 * ROW_WORDS;
    localparam int PTR_W = $clog2(CAP);
    localparam int CNT_W = $clog2(CAP + 1);
    localparam int K_W   = $clog2(ROW_WORDS + 1);
    localparam logic [CNT_W-1:0] CAP_C  = CNT_W'(CAP);
    localparam logic [CNT_W-1:0] ROOM_C = CNT_W'(CAP - ROW_WORDS);
    localparam logic [CNT_W-1:0] ROWW_C = CNT_W'(ROW_WORDS);
    localparam logic [LEN_W-1:0] LROW_C = LEN_W'(ROW_WORDS);
    localparam logic [K_W-1:0]   KROW_C = K_W'(ROW_WORDS);

    typedef struct packed {
        logic [CAP-1:0][WORD_W-1:0] mem;
        logic [PTR_W-1:0]           rd;
        logic [PTR_W-1:0]           wr;
        logic [CNT_W-1:0]           cnt;
        logic [ROW_AW-1:0]          row;
        logic [LEN_W-1:0]           left;   // words to fetch (load) or accept (store)
        sb_dir_e                    dir;
        logic                       pend;   // load row in flight
        logic [K_W-1:0]             pend_k;
    } sb_state_t;

    sb_state_t st_q, st_d;
    logic      is_load;
    logic [K_W-1:0] take;

    always_comb begin
        st_d      = st_q;
        is_load   = (st_q.dir == SB_LOAD);
        out_valid = is_load && (st_q.cnt != '0);
        out_data  = st_q.mem[st_q.rd];
        in_ready  = !is_load && (st_q.left != '0) && (st_q.cnt < CAP_C);
        done      = (st_q.left == '0) && (st_q.cnt == '0) && !st_q.pend;
        if (is_load) begin
            req  = (st_q.left != '0) && !st_q.pend && (st_q.cnt <= ROOM_C);
            take = (st_q.left >= LROW_C) ? KROW_C : st_q.left[K_W-1:0];
        end else begin
            req  = (st_q.cnt >= ROWW_C) || ((st_q.left == '0) && (st_q.cnt != '0));
            take = (st_q.cnt >= ROWW_C) ? KROW_C : st_q.cnt[K_W-1:0];
        end
        row_addr = st_q.row;
        row_we   = !is_load;
        for (int j = 0; j < ROW_WORDS; j++) begin
            row_wdata[j*WORD_W +: WORD_W] = (K_W'(j) < take) ?
                st_q.mem[st_q.rd + PTR_W'(j)] : '0;
        end

        if (is_load) begin
            if (out_valid && out_ready) begin
                st_d.rd  = st_q.rd + PTR_W'(1);
                st_d.cnt = st_d.cnt - CNT_W'(1);
            end
            if (st_q.pend) begin
                for (int j = 0; j < ROW_WORDS; j++) begin
                    if (K_W'(j) < st_q.pend_k)
                        st_d.mem[st_q.wr + PTR_W'(j)] = row_rdata[j*WORD_W +: WORD_W];
                end
                st_d.wr   = st_q.wr + PTR_W'(st_q.pend_k);
                st_d.cnt  = st_d.cnt + CNT_W'(st_q.pend_k);
                st_d.pend = 1'b0;
            end
            if (gnt) begin
                st_d.left   = st_q.left - LEN_W'(take);
                st_d.pend   = 1'b1;
                st_d.pend_k = take;
                st_d.row    = st_q.row + ROW_AW'(1);
            end
        end else begin
            if (gnt) begin
                st_d.rd  = st_q.rd + PTR_W'(take);
                st_d.cnt = st_d.cnt - CNT_W'(take);
                st_d.row = st_q.row + ROW_AW'(1);
            end
            if (in_valid && in_ready) begin
                st_d.mem[st_q.wr] = in_data;
                st_d.wr   = st_q.wr + PTR_W'(1);
                st_d.cnt  = st_d.cnt + CNT_W'(1);
                st_d.left = st_q.left - LEN_W'(1);
            end
        end

        if (cfg_valid) begin
            st_d.rd     = '0;
            st_d.wr     = '0;
            st_d.cnt    = '0;
            st_d.row    = cfg_row;
            st_d.left   = cfg_len;
            st_d.dir    = sb_dir_e'(cfg_dir);
            st_d.pend   = 1'b0;
            st_d.pend_k = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CAP_C);
    assert_return_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |=> !st_q.pend);
    assert_row_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && !cfg_valid) |=> (st_q.row == $past(st_q.row) + ROW_AW'(1)));
    assert_zero_len_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_len == '0) |=> done);
    assert_cfg_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> (!out_valid && !st_q.pend));
endmodule

// File: rtl/sbarb_srf_frontend.sv
module sbarb_srf_frontend #(
    parameter int N_STREAMS = 4,
    parameter int ROWS      = 1024,
    parameter int ROW_WORDS = 64,
    parameter int WORD_W    = 32,
    parameter int LEN_W     = 17,
    parameter int ROW_AW    = $clog2(ROWS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_STREAMS-1:0]              cfg_valid,
    input  logic [N_STREAMS-1:0][ROW_AW-1:0]  cfg_row,
    input  logic [N_STREAMS-1:0][LEN_W-1:0]   cfg_len,
    input  logic [N_STREAMS-1:0]              cfg_dir,
    input  logic [N_STREAMS-1:0]              in_valid,
    input  logic [N_STREAMS-1:0][WORD_W-1:0]  in_data,
    output logic [N_STREAMS-1:0]              in_ready,
    output logic [N_STREAMS-1:0]              out_valid,
    output logic [N_STREAMS-1:0][WORD_W-1:0]  out_data,
    input  logic [N_STREAMS-1:0]              out_ready,
    output logic [N_STREAMS-1:0]              done
);
    localparam int ROW_BITS = WORD_W * ROW_WORDS;

    logic [N_STREAMS-1:0]               req, gnt, we_v;
    logic [N_STREAMS-1:0][ROW_AW-1:0]   addr_v;
    logic [N_STREAMS-1:0][ROW_BITS-1:0] wdata_v;
    logic [ROW_AW-1:0]                  sel_addr;
    logic                               sel_we;
    logic [ROW_BITS-1:0]                sel_wdata, rdata;

    for (genvar i = 0; i < N_STREAMS; i++) begin : g_buf
        sbarb_stream_buf #(
            .WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS), .ROW_AW(ROW_AW), .LEN_W(LEN_W)
        ) u_buf (
            .clk(clk), .rst_n(rst_n),
            .cfg_valid(cfg_valid[i]), .cfg_row(cfg_row[i]),
            .cfg_len(cfg_len[i]), .cfg_dir(cfg_dir[i]),
            .in_valid(in_valid[i]), .in_data(in_data[i]), .in_ready(in_ready[i]),
            .out_valid(out_valid[i]), .out_data(out_data[i]), .out_ready(out_ready[i]),
            .done(done[i]),
            .req(req[i]), .gnt(gnt[i]),
            .row_addr(addr_v[i]), .row_we(we_v[i]),
            .row_wdata(wdata_v[i]), .row_rdata(rdata)
        );
    end

    sbarb_rr_arbiter #(.N(N_STREAMS)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt)
    );

    // one-hot grant selects the row request
    always_comb begin
        sel_addr  = '0;
        sel_we    = 1'b0;
        sel_wdata = '0;
        for (int i = 0; i < N_STREAMS; i++) begin
            if (gnt[i]) begin
                sel_addr  = sel_addr | addr_v[i];
                sel_we    = sel_we | we_v[i];
                sel_wdata = sel_wdata | wdata_v[i];
            end
        end
    end

    sbarb_row_sram #(.ROWS(ROWS), .ROW_BITS(ROW_BITS), .ROW_AW(ROW_AW)) u_sram (
        .clk(clk), .en(|gnt), .we(sel_we), .addr(sel_addr),
        .wdata(sel_wdata), .rdata(rdata)
    );
endmodule

// File: tb/sbarb_srf_frontend_test.sv
module sbarb_srf_frontend_test;
    localparam int NS = 4, RW = 64, ROWS = 1024, CAP = 128;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NS-1:0]        cfg_valid, cfg_dir, in_valid, in_ready, out_valid, out_ready, done;
    logic [NS-1:0][9:0]   cfg_row;
    logic [NS-1:0][16:0]  cfg_len;
    logic [NS-1:0][31:0]  in_data, out_data;

    sbarb_srf_frontend uut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_row(cfg_row),
        .cfg_len(cfg_len), .cfg_dir(cfg_dir), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .done(done)
    );

    int n_chk = 0, n_fail = 0;
    // bench drive variables
    bit b_cv[NS]; int b_row[NS]; int b_len[NS]; bit b_dir[NS];
    int p_in = 70, p_out = 70;
    // reference model
    int unsigned fq[NS][$];
    int unsigned pdq[NS][$];
    int unsigned got[NS][$];
    bit  m_dir[NS]; int m_row[NS]; int m_left[NS]; bit m_pend[NS];
    int  m_last = 0;
    int unsigned nextval[NS];
    int unsigned mm[int];
    bit  seen_v[NS];

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int unsigned mget(int a);
        return mm.exists(a) ? mm[a] : 0;
    endfunction

    function automatic bit m_done(int s);
        return m_left[s] == 0 && fq[s].size() == 0 && !m_pend[s];
    endfunction

    function automatic bit all_done();
        for (int s = 0; s < NS; s++) if (!m_done(s)) return 0;
        return 1;
    endfunction

    task automatic cycle();
        bit ov[NS]; bit ir[NS]; bit rq[NS]; int g;
        @(negedge clk);
        for (int s = 0; s < NS; s++) begin
            cfg_valid[s] = b_cv[s]; cfg_row[s] = 10'(b_row[s]);
            cfg_len[s] = 17'(b_len[s]); cfg_dir[s] = b_dir[s];
            in_valid[s]  = ($urandom % 100) < p_in;
            out_ready[s] = ($urandom % 100) < p_out;
            in_data[s]   = nextval[s];
        end
        #1;
        for (int s = 0; s < NS; s++) begin
            ov[s] = !m_dir[s] && fq[s].size() > 0;
            ir[s] = m_dir[s] && m_left[s] > 0 && fq[s].size() < CAP;
            if (!m_dir[s]) rq[s] = m_left[s] > 0 && !m_pend[s] && fq[s].size() <= CAP - RW;
            else rq[s] = fq[s].size() >= RW || (m_left[s] == 0 && fq[s].size() > 0);
            chk(out_valid[s] == ov[s], "R2 out_valid", out_valid[s], ov[s]);
            if (ov[s]) chk(out_data[s] == fq[s][0], "R10 R1 word order", out_data[s], fq[s][0]);
            chk(in_ready[s] == ir[s], "R9 in_ready", in_ready[s], ir[s]);
            chk(done[s] == m_done(s), "R7 done", done[s], m_done(s));
            seen_v[s] |= out_valid[s];
        end
        // round-robin grant, search after last winner
        g = -1;
        for (int off = 1; off <= NS; off++) begin
            int ix = (m_last + off) % NS;
            if (g < 0 && rq[ix]) g = ix;
        end
        for (int s = 0; s < NS; s++) begin
            if (!m_dir[s]) begin
                if (ov[s] && out_ready[s]) got[s].push_back(fq[s].pop_front());
                if (m_pend[s]) begin
                    while (pdq[s].size() > 0) fq[s].push_back(pdq[s].pop_front());
                    m_pend[s] = 0;
                end
                if (g == s) begin
                    int k = (m_left[s] >= RW) ? RW : m_left[s];
                    for (int j = 0; j < k; j++) pdq[s].push_back(mget(m_row[s]*RW + j));
                    m_left[s] -= k; m_pend[s] = 1; m_row[s] = (m_row[s] + 1) % ROWS;
                end
            end else begin
                if (g == s) begin
                    int k = (fq[s].size() >= RW) ? RW : fq[s].size();
                    for (int j = 0; j < RW; j++)
                        mm[m_row[s]*RW + j] = (j < k) ? fq[s].pop_front() : 0;
                    m_row[s] = (m_row[s] + 1) % ROWS;
                end
                if (ir[s] && in_valid[s]) begin
                    fq[s].push_back(nextval[s]); nextval[s]++; m_left[s]--;
                end
            end
            if (b_cv[s]) begin
                fq[s].delete(); pdq[s].delete(); m_pend[s] = 0;
                m_dir[s] = b_dir[s]; m_row[s] = b_row[s]; m_left[s] = b_len[s];
                b_cv[s] = 0;
            end
        end
        if (g >= 0) m_last = g;
    endtask

    task automatic setup(int s, bit dir, int row, int len);
        b_cv[s] = 1; b_dir[s] = dir; b_row[s] = row; b_len[s] = len;
    endtask

    task automatic run_done(string tag);
        int c = 0;
        while (!all_done() && c < 4000) begin cycle(); c++; end
        chk(all_done(), tag, 0, 1);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R7: streams never completed, actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(7));
        cfg_valid = '0; cfg_dir = '0; cfg_row = '0; cfg_len = '0;
        in_valid = '0; in_data = '0; out_ready = '0;
        for (int s = 0; s < NS; s++) begin
            b_cv[s] = 0; b_dir[s] = 0; b_row[s] = 0; b_len[s] = 0;
            m_dir[s] = 0; m_row[s] = 0; m_left[s] = 0; m_pend[s] = 0;
            nextval[s] = (s + 1) << 28;
        end
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(done == '1, "R8 reset done", done, 4'hf);
        chk(out_valid == '0, "R8 reset out_valid", out_valid, 0);
        chk(in_ready == '0, "R8 reset in_ready", in_ready, 0);
        rst_n = 1'b1;

        // store phase: full rows, partial row, wrap, zero length
        setup(0, 1, 10, 150);
        setup(1, 1, 20, 64);
        setup(2, 1, ROWS - 1, 70);
        setup(3, 0, 5, 0);
        cycle();
        cycle();
        chk(done[3] == 1'b1, "R7 zero length done", done[3], 1);
        run_done("R4 store streams complete");

        // load phase: all four request together
        for (int s = 0; s < NS; s++) begin got[s].delete(); seen_v[s] = 0; end
        setup(0, 0, 10, 150);
        setup(1, 0, ROWS - 1, 70);
        setup(2, 0, 20, 64);
        setup(3, 0, 12, 30);
        cycle();
        for (int c = 0; c < 8; c++) cycle();
        for (int s = 0; s < NS; s++)
            chk(seen_v[s], "R3 every stream served within a round", seen_v[s], 1);
        run_done("R2 load streams complete");
        chk(got[0].size() == 150 && got[0][0] == 32'h1000_0000 && got[0][149] == 32'h1000_0095,
            "R10 load order", got[0][149], 32'h1000_0095);
        chk(got[1].size() == 70 && got[1][64] == 32'h3000_0040, "R5 wrap to row 0",
            got[1][64], 32'h3000_0040);
        chk(got[3].size() == 30, "R6 partial load length", got[3].size(), 30);
        chk(got[3][0] == 32'h1000_0080, "R6 partial row data", got[3][0], 32'h1000_0080);
        for (int j = 22; j < 30; j++)
            chk(got[3][j] == 0, "R4 zero padding", got[3][j], 0);

        // reconfigure mid-stream
        p_out = 30;
        setup(0, 0, 10, 150);
        cycle();
        repeat (20) cycle();
        setup(0, 0, 20, 10);
        cycle();
        @(negedge clk); #1;
        chk(out_valid[0] == 1'b0, "R8 reconfig empties FIFO", out_valid[0], 0);
        got[0].delete();
        run_done("R8 reconfigured stream completes");
        chk(got[0].size() == 10 && got[0][0] == 32'h2000_0000, "R8 new row after reconfig",
            got[0][0], 32'h2000_0000);

        // mixed traffic: store beside load, then read back
        p_in = 90; p_out = 90;
        setup(1, 1, 500, 100);
        setup(2, 0, 10, 150);
        cycle();
        run_done("R1 mixed traffic completes");
        got[3].delete();
        setup(3, 0, 500, 100);
        cycle();
        run_done("R1 readback completes");
        chk(got[3].size() == 100 && got[3][0] == 32'h2000_0040 && got[3][99] == 32'h2000_00a3,
            "R1 readback data", got[3][99], 32'h2000_00a3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule